// File: doc/BRIEF.md
# Almost-Flag Offset Programming Unit

This unit holds the two threshold offsets that a FIFO's almost-empty and almost-full comparators use. The almost-empty offset is called `x_off` and the almost-full offset is called `y_off`. The unit does not compare anything itself. It only decides where the offsets come from and keeps them.

While full reset is held low, the unit samples three strap inputs on every clock. These are a programming-mode strap and a two-bit preset-select strap. The values sampled on the last clock before full reset returns high fix the loading method until the next full reset. There are three methods:

- **Fixed preset.** Both offsets load a fixed preset value.
- **Parallel load.** The first two writes after reset are taken as offset values and kept out of the memory.
- **Serial load.** A bit stream is shifted into the two offsets.

A `mem_wr` output tells the surrounding memory whether the write in the current cycle carries data. When `mem_wr` is low, the write is consumed as an offset or dropped.

Partial reset is separate from full reset. It freezes the unit while it is asserted, and it leaves the offsets, the chosen method and any pending parallel loads intact.

Top module: `ofs_prog_unit`

## Requirements
- R1: With `prog_mode`=1 and `fsel`=2'b11 sampled during full reset, both offsets equal 64 from the reset cycles onward.
- R2: With `prog_mode`=1, `fsel`=2'b01 gives both offsets 16 and `fsel`=2'b10 gives both offsets 8. Any setting with `prog_mode`=0, or with `fsel`=2'b00, clears both offsets to 0 at full reset.
- R3: With `prog_mode`=1 and `fsel`=2'b00, parallel mode is selected:
  - The first accepted write loads `wr_ofs` into `y_off`, and the second loads it into `x_off`. `wr_ofs` bit OFS_W-1 is the MSB.
  - `mem_wr` is low during both of these writes and goes high from the third write onward.
- R4: In preset and serial modes, every accepted write raises `mem_wr` in the same cycle and leaves both offsets unchanged.
- R5: With `prog_mode`=0, serial mode is selected. Each clock with `ser_en`=1 shifts `ser_in` into bit 0 of `x_off`, moves the MSB of `x_off` into bit 0 of `y_off`, and discards the MSB of `y_off`. After 2*OFS_W shifts of a word sent MSB first, `y_off` holds its upper half and `x_off` holds its lower half.
- R6: `ser_en` has no effect on the offsets outside serial mode.
- R7: While `part_rst_n`=0 (and `full_rst_n`=1), `mem_wr` is low and the offsets do not change. After release, the method and any pending parallel loads resume where they stopped.
- R8: Strap changes while `full_rst_n`=1 have no effect on the method or the offsets.
- R9: While `full_rst_n`=0, `mem_wr` stays low whatever `wr_en` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| full_rst_n | input | 1 | Full reset, active low, sampled on clk; straps are captured while it is low |
| part_rst_n | input | 1 | Partial reset, active low; holds offsets, method and pending loads |
| prog_mode | input | 1 | Programming-mode strap: 1 selects preset or parallel loading, 0 selects serial loading |
| fsel | input | 2 | Preset-select strap: 11 gives 64, 01 gives 16, 10 gives 8, 00 gives parallel load |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial data bit |
| wr_en | input | 1 | Write strobe from the FIFO's write port |
| wr_ofs | input | OFS_W | Low bits of the write data bus, used as the offset value |
| mem_wr | output | 1 | High when the current write is stored into memory |
| x_off | output | OFS_W | Almost-empty offset |
| y_off | output | OFS_W | Almost-full offset |

## Verification
In serial mode, a shift and a memory write can occur in the same cycle. The bench raises `wr_en` on every third serial shift. On those cycles it checks that `mem_wr` goes high, and it checks that the final offsets still match the shifted word, so neither action disturbs the other. Partial reset can also land between the two parallel offset writes. The bench asserts it right after the `y_off` load. It then checks that writes are blocked while partial reset is held, and that the next write after release lands in `x_off` rather than in memory.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;

  typedef enum logic [1:0] {
    CFG_SERIAL   = 2'd0,
    CFG_PRESET   = 2'd1,
    CFG_PARALLEL = 2'd2
  } cfg_mode_e;

  // Method chosen from the straps.
  function automatic cfg_mode_e decode_mode(input logic spm, input logic [1:0] fs);
    if (!spm)            return CFG_SERIAL;
    else if (fs == 2'b00) return CFG_PARALLEL;
    else                 return CFG_PRESET;
  endfunction

  // Offset value applied during full reset.
  function automatic logic [15:0] reset_offset(input logic spm, input logic [1:0] fs);
    logic [15:0] v;
    v = 16'd0;
    if (spm) begin
      unique case (fs)
        2'b11:   v = 16'd64;
        2'b01:   v = 16'd16;
        2'b10:   v = 16'd8;
        default: v = 16'd0;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/ofs_strap_capture.sv
module ofs_strap_capture
  import ofs_prog_pkg::*;
(
  input  logic       clk,
  input  logic       full_rst_n,
  input  logic       prog_mode,
  input  logic [1:0] fsel,
  output cfg_mode_e  mode
);

  always_ff @(posedge clk) begin
    if (!full_rst_n) mode <= decode_mode(prog_mode, fsel);
  end

  // R8
  mode_stable_chk: assert property (@(posedge clk) disable iff (!full_rst_n)
    full_rst_n |=> $stable(mode));

endmodule

// File: rtl/ofs_write_steer.sv
module ofs_write_steer (
  input  logic clk,
  input  logic full_rst_n,
  input  logic part_rst_n,
  input  logic arm_parallel,
  input  logic wr_en,
  output logic mem_wr,
  output logic load_y,
  output logic load_x
);

  localparam int PEND_W = 2;

  logic [PEND_W-1:0] pend;
  logic              wr_ok;

  assign wr_ok  = wr_en && full_rst_n && part_rst_n;
  assign mem_wr = wr_ok && (pend == '0);
  assign load_y = wr_ok && (pend == PEND_W'(2));
  assign load_x = wr_ok && (pend == PEND_W'(1));

  always_ff @(posedge clk) begin
    if (!full_rst_n)          pend <= arm_parallel ? PEND_W'(2) : '0;
    else if (load_y || load_x) pend <= pend - PEND_W'(1);
  end

  // R3
  pend_step_chk: assert property (@(posedge clk) disable iff (!full_rst_n)
    (load_y || load_x) |=> (pend == $past(pend) - PEND_W'(1)));

endmodule

// File: rtl/ofs_regs.sv
module ofs_regs #(
  parameter int OFS_W = 10
) (
  input  logic             clk,
  input  logic             full_rst_n,
  input  logic             part_rst_n,
  input  logic [OFS_W-1:0] rst_value,
  input  logic             serial_mode,
  input  logic             ser_en,
  input  logic             ser_in,
  input  logic             load_y,
  input  logic             load_x,
  input  logic [OFS_W-1:0] wr_ofs,
  output logic [OFS_W-1:0] x_off,
  output logic [OFS_W-1:0] y_off
);

  logic shift_evt;

  assign shift_evt = serial_mode && ser_en && full_rst_n && part_rst_n;

  always_ff @(posedge clk) begin
    if (!full_rst_n) begin
      x_off <= rst_value;
      y_off <= rst_value;
    end else if (shift_evt) begin
      y_off <= {y_off[OFS_W-2:0], x_off[OFS_W-1]};
      x_off <= {x_off[OFS_W-2:0], ser_in};
    end else begin
      if (load_y) y_off <= wr_ofs;
      if (load_x) x_off <= wr_ofs;
    end
  end

  // R3
  y_load_chk: assert property (@(posedge clk) disable iff (!full_rst_n)
    load_y |=> (y_off == $past(wr_ofs)));

  // R7
  part_hold_chk: assert property (@(posedge clk) disable iff (!full_rst_n)
    !part_rst_n |=> ($stable(x_off) && $stable(y_off)));

endmodule

// File: rtl/ofs_prog_unit.sv
module ofs_prog_unit
  import ofs_prog_pkg::*;
#(
  parameter int OFS_W = 10
) (
  input  logic             clk,
  input  logic             full_rst_n,
  input  logic             part_rst_n,
  input  logic             prog_mode,
  input  logic [1:0]       fsel,
  input  logic             ser_en,
  input  logic             ser_in,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  output logic             mem_wr,
  output logic [OFS_W-1:0] x_off,
  output logic [OFS_W-1:0] y_off
);

  cfg_mode_e        mode;
  logic             arm_parallel;
  logic             load_y;
  logic             load_x;
  logic [OFS_W-1:0] rst_value;
  logic [15:0]      rst_full;

  assign arm_parallel = (decode_mode(prog_mode, fsel) == CFG_PARALLEL);
  assign rst_full     = reset_offset(prog_mode, fsel);
  assign rst_value    = rst_full[OFS_W-1:0];

  ofs_strap_capture i_straps (
    .clk        (clk),
    .full_rst_n (full_rst_n),
    .prog_mode  (prog_mode),
    .fsel       (fsel),
    .mode       (mode)
  );

  ofs_write_steer i_steer (
    .clk          (clk),
    .full_rst_n   (full_rst_n),
    .part_rst_n   (part_rst_n),
    .arm_parallel (arm_parallel),
    .wr_en        (wr_en),
    .mem_wr       (mem_wr),
    .load_y       (load_y),
    .load_x       (load_x)
  );

  ofs_regs #(.OFS_W(OFS_W)) i_regs (
    .clk         (clk),
    .full_rst_n  (full_rst_n),
    .part_rst_n  (part_rst_n),
    .rst_value   (rst_value),
    .serial_mode (mode == CFG_SERIAL),
    .ser_en      (ser_en),
    .ser_in      (ser_in),
    .load_y      (load_y),
    .load_x      (load_x),
    .wr_ofs      (wr_ofs),
    .x_off       (x_off),
    .y_off       (y_off)
  );

  // R4
  preset_pass_chk: assert property (@(posedge clk) disable iff (!full_rst_n)
    (mode != CFG_PARALLEL && wr_en && part_rst_n) |-> mem_wr);

endmodule

// File: tb/test_ofs_prog_unit.sv
module test_ofs_prog_unit;

  localparam int W = 10;

  logic         clk = 1'b0;
  logic         full_rst_n = 1'b0, part_rst_n = 1'b1;
  logic         prog_mode = 1'b0, ser_en = 1'b0, ser_in = 1'b0, wr_en = 1'b0;
  logic [1:0]   fsel = 2'b00;
  logic [W-1:0] wr_ofs = '0;
  logic         mem_wr;
  logic [W-1:0] x_off, y_off;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ofs_prog_unit #(.OFS_W(W)) i_ofs_prog_unit (
    .clk(clk), .full_rst_n(full_rst_n), .part_rst_n(part_rst_n),
    .prog_mode(prog_mode), .fsel(fsel), .ser_en(ser_en), .ser_in(ser_in),
    .wr_en(wr_en), .wr_ofs(wr_ofs), .mem_wr(mem_wr), .x_off(x_off), .y_off(y_off)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_preset(input bit spm, input bit [1:0] fs);
    if (spm && fs[0] && fs[1]) return 64;
    if (spm && fs[0])          return 16;
    if (spm && fs[1])          return 8;
    return 0;
  endfunction

  // Full reset with given straps; straps are inverted after release (R8).
  task automatic full_reset(input bit spm, input bit [1:0] fs);
    full_rst_n = 0; prog_mode = spm; fsel = fs; wr_en = 1; ser_en = 0;
    tick(); tick();
    chk("R9", "mem_wr in reset", int'(mem_wr), 0);
    full_rst_n = 1; wr_en = 0;
    tick();
    prog_mode = ~spm; fsel = ~fs;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 8; c++) begin
      bit spm;
      bit [1:0] fs;
      int e;
      spm = c[2]; fs = c[1:0];
      e = exp_preset(spm, fs);
      full_reset(spm, fs);
      chk(e == 64 ? "R1" : "R2", "x_off after reset", int'(x_off), e);
      chk(e == 64 ? "R1" : "R2", "y_off after reset", int'(y_off), e);
      if (spm && fs == 2'b00) begin
        wr_en = 1; wr_ofs = W'(10'h2A5 + c);
        #1 chk("R3", "mem_wr on 1st write", int'(mem_wr), 0);
        tick();
        chk("R3", "y_off from 1st write", int'(y_off), 10'h2A5 + c);
        chk("R3", "x_off untouched", int'(x_off), 0);
        wr_ofs = W'(10'h13C);
        #1 chk("R3", "mem_wr on 2nd write", int'(mem_wr), 0);
        tick();
        chk("R8", "x_off from 2nd write despite strap change", int'(x_off), 10'h13C);
        wr_ofs = W'(10'h3FF);
        #1 chk("R3", "mem_wr on 3rd write", int'(mem_wr), 1);
        tick();
        chk("R3", "y_off after data write", int'(y_off), 10'h2A5 + c);
        wr_en = 0; ser_en = 1; ser_in = 1;
        tick(); tick();
        ser_en = 0;
        chk("R6", "x_off with ser_en in parallel mode", int'(x_off), 10'h13C);
      end else if (spm) begin
        wr_en = 1; wr_ofs = W'(10'h155);
        #1 chk("R4", "mem_wr in preset mode", int'(mem_wr), 1);
        tick(); tick();
        wr_en = 0;
        chk("R4", "y_off after preset write", int'(y_off), e);
        ser_en = 1; ser_in = 1;
        tick(); tick(); tick();
        ser_en = 0;
        chk("R6", "x_off with ser_en in preset mode", int'(x_off), e);
      end else begin
        logic [2*W-1:0] pat;
        pat = 20'hA5C3E ^ (20'h1111 * c);
        for (int i = 2*W-1; i >= 0; i--) begin
          ser_en = 1; ser_in = pat[i];
          wr_en = (i % 3 == 0);
          #1 if (wr_en) chk("R4", "mem_wr during serial shift", int'(mem_wr), 1);
          tick();
        end
        ser_en = 0; wr_en = 0;
        chk("R5", "y_off after shift", int'(y_off), int'(pat[2*W-1:W]));
        chk("R5", "x_off after shift", int'(x_off), int'(pat[W-1:0]));
      end
    end

    // Partial reset between the two parallel offset writes (R7).
    full_reset(1'b1, 2'b00);
    wr_en = 1; wr_ofs = W'(10'h0F0);
    tick();
    part_rst_n = 0; wr_ofs = W'(10'h00F);
    #1 chk("R7", "mem_wr during partial reset", int'(mem_wr), 0);
    tick(); tick();
    chk("R7", "y_off held", int'(y_off), 10'h0F0);
    chk("R7", "x_off held", int'(x_off), 0);
    part_rst_n = 1; wr_ofs = W'(10'h222);
    #1 chk("R7", "pending write resumes", int'(mem_wr), 0);
    tick();
    chk("R7", "x_off loaded after partial reset", int'(x_off), 10'h222);
    #1 chk("R7", "data write after loads", int'(mem_wr), 1);
    wr_en = 0;

    // Partial reset in preset mode keeps the preset.
    full_reset(1'b1, 2'b01);
    part_rst_n = 0; wr_en = 1;
    tick(); tick();
    part_rst_n = 1; wr_en = 0;
    tick();
    chk("R7", "preset kept over partial reset", int'(x_off), 16);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule